// File: doc/BRIEF.md
# Frame Capture Control Sequencer

This block is the control word and sequencing core of a display writeback engine. Software writes one 32-bit control word to arm a single-frame capture. The sequencer then waits for the pixel source to signal frame start, lets memory writes run until the address generator reports end of frame, and drains for a short, fixed number of cycles before it returns to idle. The same word reads back the busy flag, the stored option bits and a fixed identification field.

Software can end a frame early with an abort request, which stops memory writes on the next cycle. It can also ask for a frame-start request to be issued again at every end of frame, or hold the capture buffer memory powered down, which blocks any start. A level interrupt is asserted whenever the block is idle with interrupts enabled. Software clears it by writing the enable bit to 0.

Top module: `fcap_ctrl_top`

## Requirements
- R1: A write with bit 0 set, made while idle, with bit 14 clear and bit 21 clear in the same write, is accepted. After the write edge, busy (bit 1) reads 1 and `frame_req` is high for exactly one cycle. Bit 0 always reads 0.
- R2: Busy reads 1 from an accepted start until the sequencer is idle again. While busy, the sequencer is either waiting for frame start, capturing, or draining.
- R3: Capture begins at the first `src_vstart` sampled while waiting. `cap_wr_en` is high only during capture. An `src_eof` sampled during capture starts a drain of DONE_CYCLES cycles, and busy clears at the end of that drain.
- R4: `irq` is high exactly when bit 2 (interrupt enable) is stored as 1 and the sequencer is idle. A write that clears bit 2 drops `irq` after that write edge.
- R5: A write with bit 14 set while busy ends the frame. `cap_wr_en` is low after that edge, and busy clears within DONE_CYCLES+1 cycles, never more than 4. Bit 14 reads 0.
- R6: While bit 15 is stored as 1, an `src_eof` that ends a capture pulses `frame_req` for one cycle after the edge.
- R7: Bit 21 is stored on every write, reads back and drives `mem_pwrdn`. A start written with bit 21 set is not accepted.
- R8: Bits 31:24 read 0x54, bits 23:22 read 01, and every bit not named in R1 to R7 reads 0.
- R9: A start written while busy is ignored: no `frame_req` and no change of state. Bits 2, 15 and 21 are still updated by that write.
- R10: `src_vstart` has no effect unless the sequencer is waiting for frame start. `src_eof` has no effect unless it is capturing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write data |
| csr_rdata | output | 32 | Control word readback |
| src_vstart | input | 1 | Frame-start event from the pixel source |
| src_eof | input | 1 | End-of-frame event from the address generator |
| frame_req | output | 1 | One-cycle frame-start request to the pixel source |
| cap_wr_en | output | 1 | Memory writes permitted (capture phase) |
| mem_pwrdn | output | 1 | Capture buffer memory power-down |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DONE_CYCLES = 2. That drain length is long enough to catch an abort or a second start arriving during the drain. It also places the abort-to-idle bound at 3 cycles, inside the 4-cycle limit. A behavioural model is stepped every clock and compared on readback, `irq`, `frame_req`, `cap_wr_en` and `mem_pwrdn`. The stimulus includes stray frame events in the wrong phase, aborts both while waiting and while capturing, and frame regeneration left enabled across two back-to-back ends of frame.

// File: rtl/fcap_pkg.sv
// Package: shared sequencer state and control word field positions.
// Assumes a 32-bit control word; positions are fixed by the software view.
package fcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CAP   = 2'd2,
        ST_DRAIN = 2'd3
    } fcap_state_e;

    localparam int CSR_W      = 32;
    localparam int B_START    = 0;
    localparam int B_BUSY     = 1;
    localparam int B_IE       = 2;
    localparam int B_ABORT    = 14;
    localparam int B_REGEN    = 15;
    localparam int B_PWRDN    = 21;
    localparam int F_VER_LO   = 22;
    localparam int F_ID_LO    = 24;
endpackage

// File: rtl/fcap_regs.sv
// Module: fcap_regs
// Holds the stored option bits of the control word, decodes the self-clearing
// start and abort requests of a write, and assembles the readback word.
// Assumes one write per strobe cycle; reads are combinational from state.
module fcap_regs
    import fcap_pkg::*;
#(
    parameter logic [7:0] ID_CODE  = 8'h54,
    parameter logic [1:0] VER_CODE = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             busy,
    output logic             go_req,
    output logic             abort_req,
    output logic             pd_wr,
    output logic             opt_ie,
    output logic             opt_regen,
    output logic             opt_pd,
    output logic [CSR_W-1:0] csr_rdata
);
    // Purpose: capture the persistent option bits on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_ie    <= 1'b0;
            opt_regen <= 1'b0;
            opt_pd    <= 1'b0;
        end else if (csr_wr) begin
            opt_ie    <= csr_wdata[B_IE];
            opt_regen <= csr_wdata[B_REGEN];
            opt_pd    <= csr_wdata[B_PWRDN];
        end
    end

    // Purpose: decode the self-clearing requests carried by this write.
    always_comb begin
        go_req    = csr_wr & csr_wdata[B_START];
        abort_req = csr_wr & csr_wdata[B_ABORT];
        pd_wr     = csr_wdata[B_PWRDN];
    end

    // Purpose: assemble the readback word; self-clearing bits read 0.
    always_comb begin
        csr_rdata                        = '0;
        csr_rdata[F_ID_LO +: 8]          = ID_CODE;
        csr_rdata[F_VER_LO +: 2]         = VER_CODE;
        csr_rdata[B_PWRDN]               = opt_pd;
        csr_rdata[B_REGEN]               = opt_regen;
        csr_rdata[B_IE]                  = opt_ie;
        csr_rdata[B_BUSY]                = busy;
    end

    AST_IE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (opt_ie == $past(csr_wdata[B_IE]))); // R4
    AST_PD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (opt_pd == $past(csr_wdata[B_PWRDN]))); // R7
endmodule

// File: rtl/fcap_fsm.sv
// Module: fcap_fsm
// Sequences one capture: idle, wait for frame start, capture until end of
// frame, then a fixed drain before idle. Abort jumps straight to the drain.
// Assumes frame events are single-cycle pulses synchronous to clk.
module fcap_fsm
    import fcap_pkg::*;
#(
    parameter int DONE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic abort_req,
    input  logic pd_wr,
    input  logic opt_regen,
    input  logic src_vstart,
    input  logic src_eof,
    output logic busy,
    output logic cap_wr_en,
    output logic frame_req
);
    localparam int CNT_W = $clog2(DONE_CYCLES + 1);
    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DONE_CYCLES - 1);

    fcap_state_e      state, state_nx;
    logic [CNT_W-1:0] drain_cnt, drain_cnt_nx;
    logic             req_nx;

    // Purpose: next-state, drain counter and frame request decisions.
    always_comb begin
        state_nx     = state;
        drain_cnt_nx = drain_cnt;
        req_nx       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go_req && !abort_req && !pd_wr) begin
                    state_nx = ST_WAIT;
                    req_nx   = 1'b1;
                end
            end
            ST_WAIT: begin
                if (abort_req) begin
                    state_nx     = ST_DRAIN;
                    drain_cnt_nx = DRAIN_LAST;
                end else if (src_vstart) begin
                    state_nx = ST_CAP;
                end
            end
            ST_CAP: begin
                if (abort_req) begin
                    state_nx     = ST_DRAIN;
                    drain_cnt_nx = DRAIN_LAST;
                end else if (src_eof) begin
                    state_nx     = ST_DRAIN;
                    drain_cnt_nx = DRAIN_LAST;
                    req_nx       = opt_regen;
                end
            end
            ST_DRAIN: begin
                if (drain_cnt == '0) state_nx = ST_IDLE;
                else                 drain_cnt_nx = drain_cnt - 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Purpose: register state, counter and the one-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            drain_cnt <= '0;
            frame_req <= 1'b0;
        end else begin
            state     <= state_nx;
            drain_cnt <= drain_cnt_nx;
            frame_req <= req_nx;
        end
    end

    // Purpose: derive status and write permission from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        cap_wr_en = (state == ST_CAP);
    end

    AST_CAP_NEEDS_VSTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wr_en && !$past(cap_wr_en)) |-> ($past(state == ST_WAIT) && $past(src_vstart))); // R3
    AST_ABORT_STOPS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_req) |=> !cap_wr_en); // R5
    AST_PWRDN_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go_req && pd_wr) |=> !busy); // R7
    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req |-> ($past(state == ST_IDLE) || ($past(state == ST_CAP) && $past(src_eof) && $past(opt_regen)))); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req && !src_eof) |=> !frame_req); // R9
endmodule

// File: rtl/fcap_ctrl_top.sv
// Module: fcap_ctrl_top
// Control word plus capture sequencer for a single-frame writeback engine.
// Assumes DONE_CYCLES in 1..3 so that an abort reaches idle within 4 cycles.
module fcap_ctrl_top
    import fcap_pkg::*;
#(
    parameter int         DONE_CYCLES = 1,
    parameter logic [7:0] ID_CODE     = 8'h54,
    parameter logic [1:0] VER_CODE    = 2'b01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        src_vstart,
    input  logic        src_eof,
    output logic        frame_req,
    output logic        cap_wr_en,
    output logic        mem_pwrdn,
    output logic        irq
);
    logic go_req, abort_req, pd_wr;
    logic opt_ie, opt_regen, opt_pd;
    logic busy;

    fcap_regs #(.ID_CODE(ID_CODE), .VER_CODE(VER_CODE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .busy      (busy),
        .go_req    (go_req),
        .abort_req (abort_req),
        .pd_wr     (pd_wr),
        .opt_ie    (opt_ie),
        .opt_regen (opt_regen),
        .opt_pd    (opt_pd),
        .csr_rdata (csr_rdata)
    );

    fcap_fsm #(.DONE_CYCLES(DONE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_req     (go_req),
        .abort_req  (abort_req),
        .pd_wr      (pd_wr),
        .opt_regen  (opt_regen),
        .src_vstart (src_vstart),
        .src_eof    (src_eof),
        .busy       (busy),
        .cap_wr_en  (cap_wr_en),
        .frame_req  (frame_req)
    );

    // Purpose: level interrupt while idle with interrupts enabled.
    always_comb begin
        irq       = opt_ie & ~busy;
        mem_pwrdn = opt_pd;
    end

    AST_IRQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !csr_wdata[B_IE]) |=> !irq); // R4
endmodule

// File: tb/tb_fcap_ctrl_top.sv
`timescale 1ns/1ps
module tb_fcap_ctrl_top;
    localparam int DC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        src_vstart = 1'b0;
    logic        src_eof = 1'b0;
    logic        frame_req, cap_wr_en, mem_pwrdn, irq;

    int checks = 0;
    int errors = 0;

    // model state: 0 idle, 1 waiting, 2 capturing, 3 draining
    int m_phase = 0;
    int m_left  = 0;
    bit m_ie = 0, m_regen = 0, m_pd = 0, m_req = 0;

    fcap_ctrl_top #(.DONE_CYCLES(DC)) dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .src_vstart(src_vstart), .src_eof(src_eof),
        .frame_req(frame_req), .cap_wr_en(cap_wr_en), .mem_pwrdn(mem_pwrdn),
        .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = 32'h5440_0000;
        w[21] = m_pd; w[15] = m_regen; w[2] = m_ie; w[1] = (m_phase != 0);
        return w;
    endfunction

    task automatic compare_all();
        check("R2 readback", csr_rdata, exp_word());
        check("R3 cap_wr_en", {31'd0, cap_wr_en}, {31'd0, m_phase == 2});
        check("R4 irq", {31'd0, irq}, {31'd0, m_ie && m_phase == 0});
        check("R1 frame_req", {31'd0, frame_req}, {31'd0, m_req});
        check("R7 mem_pwrdn", {31'd0, mem_pwrdn}, {31'd0, m_pd});
    endtask

    // one clock: model follows the inputs, then outputs are compared
    task automatic tick();
        int  np = m_phase, nl = m_left;
        bit  nr = 0;
        bit  go = csr_wr && csr_wdata[0];
        bit  ab = csr_wr && csr_wdata[14];
        if (m_phase == 0) begin
            if (go && !ab && !csr_wdata[21]) begin np = 1; nr = 1; end
        end else if (m_phase == 3) begin
            if (m_left == 1) np = 0; else nl = m_left - 1;
        end else if (ab) begin
            np = 3; nl = DC;
        end else if (m_phase == 1 && src_vstart) begin
            np = 2;
        end else if (m_phase == 2 && src_eof) begin
            np = 3; nl = DC; nr = m_regen;
        end
        @(posedge clk);
        #1;
        if (csr_wr) begin m_ie = csr_wdata[2]; m_regen = csr_wdata[15]; m_pd = csr_wdata[21]; end
        m_phase = np; m_left = nl; m_req = nr;
        compare_all();
    endtask

    task automatic write_word(input logic [31:0] d);
        csr_wr = 1'b1; csr_wdata = d;
        tick();
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic pulse_vs();
        src_vstart = 1'b1; tick(); src_vstart = 1'b0;
    endtask

    task automatic pulse_eof();
        src_eof = 1'b1; tick(); src_eof = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state, R8 constant fields
        check("R8 reset readback", csr_rdata, 32'h5440_0000);
        check("R4 reset irq", {31'd0, irq}, 32'd0);
        idle(2);

        // R1/R2/R3 normal frame with interrupt enable
        write_word(32'h0000_0005);
        check("R1 start reads 0", {31'd0, csr_rdata[0]}, 32'd0);
        check("R1 busy after start", {31'd0, csr_rdata[1]}, 32'd1);
        idle(3);
        pulse_eof();                    // R10: eof while waiting ignored
        check("R10 eof in wait", {31'd0, csr_rdata[1]}, 32'd1);
        pulse_vs();
        check("R3 capturing", {31'd0, cap_wr_en}, 32'd1);
        pulse_vs();                     // R10: second vstart ignored
        idle(4);
        pulse_eof();
        check("R6 no regen pulse", {31'd0, frame_req}, 32'd0);
        idle(DC + 1);
        check("R4 irq after frame", {31'd0, irq}, 32'd1);
        pulse_vs();                     // R10: vstart while idle ignored
        check("R10 vstart idle", {31'd0, csr_rdata[1]}, 32'd0);
        write_word(32'h0000_0000);      // R4 acknowledge
        check("R4 irq cleared", {31'd0, irq}, 32'd0);

        // R9 start while busy ignored but options updated
        write_word(32'h0000_0001);
        write_word(32'h0020_8005);
        check("R9 no req while busy", {31'd0, frame_req}, 32'd0);
        check("R9 options updated", {31'd0, csr_rdata[15]}, 32'd1);
        pulse_vs();
        // R6 regen at eof
        pulse_eof();
        check("R6 regen pulse", {31'd0, frame_req}, 32'd1);
        write_word(32'h0000_8001);      // R9 start during drain ignored
        idle(DC + 1);
        check("R2 idle after drain", {31'd0, csr_rdata[1]}, 32'd0);

        // R7 power-down blocks start
        write_word(32'h0020_0001);
        check("R7 start blocked", {31'd0, csr_rdata[1]}, 32'd0);
        check("R7 pwrdn readback", {31'd0, csr_rdata[21]}, 32'd1);
        idle(2);

        // R5 abort while capturing
        write_word(32'h0000_0001);
        pulse_vs();
        idle(2);
        write_word(32'h0000_4000);
        check("R5 writes stop", {31'd0, cap_wr_en}, 32'd0);
        check("R5 abort reads 0", {31'd0, csr_rdata[14]}, 32'd0);
        begin
            int n = 1;
            while (csr_rdata[1] && n < 10) begin tick(); n++; end
            check("R5 busy bound", {31'd0, n <= DC + 1 && n <= 4}, 32'd1);
        end

        // R5 abort while waiting, then a clean frame with regen back-to-back
        write_word(32'h0000_0001);
        write_word(32'h0000_4000);
        idle(DC + 1);
        write_word(32'h0000_8001);
        pulse_vs();
        pulse_eof();
        idle(DC + 2);
        check("R2 final idle", {31'd0, csr_rdata[1]}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule